// File: doc/BRIEF.md
# Sigma-Delta Modulator Filter Channel

This block is one receive channel for a single-bit sigma-delta modulator. The modulator clock and data pins are brought into the system clock domain. On every rising edge of the modulator clock, one data bit is taken, so the clock rate equals the data rate. Each bit feeds two independent third-order sinc decimators. The precision decimator runs at a large oversampling ratio. Its full-width output is scaled to a signed 16-bit result by a fixed arithmetic right shift and then saturated. The fast decimator runs at a smaller ratio. Its output is compared against a programmable upper limit and a programmable lower limit.

Four sticky flags report events: a new result, an upper crossing, a lower crossing and a stalled modulator clock. The system clock counts cycles since the last modulator edge to detect a stalled clock. Both decimators and the stall detector run only while the channel enable and the shared master enable are both high. All of their state is held cleared otherwise. As a result, raising the master enable after several channels have been enabled starts every channel's decimation phase on the same modulator edge. A single interrupt line merges the flags through per-flag enables and a master interrupt enable.

Top module: `sdm_channel`

## Requirements
- R1: While `chan_en` and `master_en` are not both 1, both decimators and the stall counter are held cleared, `result` keeps its value, and no flag is set by the channel.
- R2: After run begins (both enables 1), the first data-ready flag is set on exactly the `DATA_OSR`-th sampled modulator rising edge. It is not set on the edge before.
- R3: One data bit is taken per modulator rising edge, with 1 counting as +1 and 0 as -1. For a periodic bit pattern whose period divides the ratio, the settled precision output equals the pattern's mean times `DATA_OSR`^3.
- R4: `result` is the full-width precision output shifted right arithmetically by `OUT_SHIFT`, then clamped to the range -32768..32767.
- R5: The fast decimator (ratio `CMP_OSR`) sets flag bit 1 when an output is strictly greater than `cmp_hi`. It sets flag bit 2 when an output is strictly less than `cmp_lo`. Both limits are signed.
- R6: Flag bit 0 (data ready) is set on the same clock edge that loads each new `result`.
- R7: Flag bit 3 (modulator failure) is set while running once more than max(`fail_tmo`, 64) system clocks have passed since the last sampled modulator edge. A `fail_tmo` value below 64 acts as 64.
- R8: Flags stay set until a 1 is written to the same bit of `flag_clr`. A flag source that is active in the same cycle keeps its flag set.
- R9: `irq` is high exactly when `master_irq_en` is 1 and at least one flag is 1 with the same bit of `irq_en` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_clk | input | 1 | Modulator clock pin (asynchronous) |
| mod_dat | input | 1 | Modulator data pin (asynchronous) |
| chan_en | input | 1 | Channel enable |
| master_en | input | 1 | Shared master filter enable |
| cmp_hi | input | TH_W | Signed upper limit for the fast path |
| cmp_lo | input | TH_W | Signed lower limit for the fast path |
| fail_tmo | input | TMO_W | Stall timeout in system clocks (minimum 64) |
| irq_en | input | 4 | Per-flag interrupt enables, same bit order as `flags` |
| master_irq_en | input | 1 | Master interrupt enable |
| flag_clr | input | 4 | Write-one-to-clear pulses for `flags` |
| result | output | 16 | Signed formatted precision result |
| flags | output | 4 | Sticky flags: 0 ready, 1 upper, 2 lower, 3 failure |
| irq | output | 1 | Interrupt request |

## Verification
Timing is counted from a rising edge on `mod_clk`. The edge is seen as a strobe after the second system clock edge. `result` and the ready and limit flags update on the third edge, and `irq` follows the flags in the same cycle. The failure flag sets one edge after the stall count passes the timeout. The bench holds each modulator bit for eight system clocks and samples at falling edges only after a bit's whole window has passed, so every three-edge latency has already elapsed. Stall checks use margins of about ten cycles on either side of the timeout.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
   localparam int ORDER   = 3;   // sinc order of both decimators
   localparam int OUT_W   = 16;  // formatted result width
   localparam int FLG_N   = 4;
   localparam int FLG_RDY = 0;   // new data result
   localparam int FLG_HI  = 1;   // fast path above upper limit
   localparam int FLG_LO  = 2;   // fast path below lower limit
   localparam int FLG_MF  = 3;   // modulator clock stalled
   localparam int MIN_TMO = 64;  // floor on the stall timeout
endpackage

// File: rtl/sdm_insync.sv
// Brings the modulator pins into the system domain; strobe marks a rising edge.
module sdm_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mod_clk,
   input  logic mod_dat,
   output logic strobe,
   output logic bit_out
);
   logic [STAGES:0]   clk_q;
   logic [STAGES-1:0] dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_q <= '0;
         dat_q <= '0;
      end else begin
         clk_q <= {clk_q[STAGES-1:0], mod_clk};
         dat_q <= {dat_q[STAGES-2:0], mod_dat};
      end
   end

   assign strobe  = clk_q[STAGES-1] & ~clk_q[STAGES];
   assign bit_out = dat_q[STAGES-1];
endmodule

// File: rtl/sdm_sinc3.sv
// Wrapping integrators at the bit rate, differentiators at the decimated rate.
module sdm_sinc3 #(
   parameter int OSR   = 128,
   parameter int ACC_W = sdm_pkg::ORDER * $clog2(OSR) + 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    run,
   input  logic                    strobe,
   input  logic                    bit_in,
   output logic                    fire,
   output logic signed [ACC_W-1:0] value
);
   localparam int CNT_W = $clog2(OSR);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   logic [CNT_W-1:0]        phase;
   logic signed [ACC_W-1:0] x;

   assign x    = bit_in ? ACC_W'(1) : '1;
   assign fire = run & strobe & (phase == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase <= '0;
      else if (!run)   phase <= '0;
      else if (strobe) phase <= phase + 1'b1;
   end

   for (genvar g = 0; g < sdm_pkg::ORDER; g++) begin : g_int
      logic signed [ACC_W-1:0] acc;
      logic signed [ACC_W-1:0] feed;
      if (g == 0) begin : g_first
         assign feed = x;
      end else begin : g_next
         assign feed = g_int[g-1].acc;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      acc <= '0;
         else if (!run)   acc <= '0;
         else if (strobe) acc <= acc + feed;
      end
   end

   for (genvar g = 0; g < sdm_pkg::ORDER; g++) begin : g_cmb
      logic signed [ACC_W-1:0] cin;
      logic signed [ACC_W-1:0] dly;
      logic signed [ACC_W-1:0] dif;
      if (g == 0) begin : g_first
         assign cin = g_int[sdm_pkg::ORDER-1].acc;
      end else begin : g_next
         assign cin = g_cmb[g-1].dif;
      end
      assign dif = cin - dly;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    dly <= '0;
         else if (!run) dly <= '0;
         else if (fire) dly <= cin;
      end
   end

   assign value = g_cmb[sdm_pkg::ORDER-1].dif;
endmodule

// File: rtl/sdm_clkmon.sv
// Counts system clocks since the last modulator edge.
module sdm_clkmon #(
   parameter int TMO_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             strobe,
   input  logic [TMO_W-1:0] tmo,
   output logic             stalled
);
   localparam int CW = TMO_W + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] limit;

   assign limit   = (tmo < TMO_W'(sdm_pkg::MIN_TMO)) ? CW'(sdm_pkg::MIN_TMO) : CW'(tmo);
   assign stalled = run & (cnt > limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || strobe) cnt <= '0;
      else if (cnt != '1)      cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sdm_channel.sv
module sdm_channel #(
   parameter int DATA_OSR    = 128,
   parameter int CMP_OSR     = 32,
   parameter int OUT_SHIFT   = 8,
   parameter int TH_W        = 16,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          mod_clk,
   input  logic                          mod_dat,
   input  logic                          chan_en,
   input  logic                          master_en,
   input  logic signed [TH_W-1:0]        cmp_hi,
   input  logic signed [TH_W-1:0]        cmp_lo,
   input  logic [TMO_W-1:0]              fail_tmo,
   input  logic [sdm_pkg::FLG_N-1:0]     irq_en,
   input  logic                          master_irq_en,
   input  logic [sdm_pkg::FLG_N-1:0]     flag_clr,
   output logic signed [sdm_pkg::OUT_W-1:0] result,
   output logic [sdm_pkg::FLG_N-1:0]     flags,
   output logic                          irq
);
   import sdm_pkg::*;

   localparam int DACC_W = ORDER * $clog2(DATA_OSR) + 2;
   localparam int CACC_W = ORDER * $clog2(CMP_OSR) + 2;

   // elaboration-time parameter checks
   if (DATA_OSR < 4 || (DATA_OSR & (DATA_OSR - 1)) != 0) begin : g_bad_dosr
      $error("DATA_OSR must be a power of two of at least 4");
   end
   if (CMP_OSR < 4 || (CMP_OSR & (CMP_OSR - 1)) != 0) begin : g_bad_cosr
      $error("CMP_OSR must be a power of two of at least 4");
   end
   if (DACC_W > 32 || CACC_W > 32 || TH_W > 32) begin : g_bad_w
      $error("accumulator or limit width exceeds 32 bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (OUT_SHIFT < 0 || OUT_SHIFT >= DACC_W) begin : g_bad_shift
      $error("OUT_SHIFT out of range");
   end

   logic run, strobe, sbit;
   logic dfire, cfire, stalled;
   logic signed [DACC_W-1:0] dval;
   logic signed [CACC_W-1:0] cval;
   logic signed [OUT_W-1:0]  fmt;
   int                       shifted;
   logic [FLG_N-1:0]         set_v;

   assign run = chan_en & master_en;

   sdm_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .mod_clk(mod_clk), .mod_dat(mod_dat),
      .strobe(strobe), .bit_out(sbit)
   );

   sdm_sinc3 #(.OSR(DATA_OSR), .ACC_W(DACC_W)) u_dflt (
      .clk(clk), .rst_n(rst_n), .run(run), .strobe(strobe), .bit_in(sbit),
      .fire(dfire), .value(dval)
   );

   sdm_sinc3 #(.OSR(CMP_OSR), .ACC_W(CACC_W)) u_cflt (
      .clk(clk), .rst_n(rst_n), .run(run), .strobe(strobe), .bit_in(sbit),
      .fire(cfire), .value(cval)
   );

   sdm_clkmon #(.TMO_W(TMO_W)) u_mon (
      .clk(clk), .rst_n(rst_n), .run(run), .strobe(strobe), .tmo(fail_tmo),
      .stalled(stalled)
   );

   assign shifted = int'(dval) >>> OUT_SHIFT;

   if (DACC_W - OUT_SHIFT > OUT_W) begin : g_sat
      always_comb begin
         if (shifted > 32767)       fmt = 16'sh7FFF;
         else if (shifted < -32768) fmt = 16'sh8000;
         else                       fmt = OUT_W'(shifted);
      end
   end else begin : g_ext
      assign fmt = OUT_W'(shifted);
   end

   always_comb begin
      set_v          = '0;
      set_v[FLG_RDY] = dfire;
      set_v[FLG_HI]  = cfire && (int'(cval) > int'(cmp_hi));
      set_v[FLG_LO]  = cfire && (int'(cval) < int'(cmp_lo));
      set_v[FLG_MF]  = stalled;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         flags  <= '0;
      end else begin
         if (dfire) result <= fmt;
         flags <= (flags & ~flag_clr) | set_v;
      end
   end

   assign irq = master_irq_en & |(flags & irq_en);
endmodule

// File: rtl/sdm_channel_chk.sv
module sdm_channel_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        chan_en,
   input logic        master_en,
   input logic [3:0]  flag_clr,
   input logic [3:0]  flags,
   input logic [15:0] result,
   input logic        irq
);
   // R1: result frozen while the channel is not running
   assert_hold_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(chan_en && master_en) |=> $stable(result));

   // R6: a new data-ready flag only appears while running
   assert_ready_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> $past(chan_en && master_en));

   // R5: limit flags only appear while running
   assert_limit_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[1]) || $rose(flags[2])) |-> $past(chan_en && master_en));

   // R7: stall flag only appears while running
   assert_fail_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[3]) |-> $past(chan_en && master_en));

   // R8: set flags not cleared stay set
   assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~flag_clr) != 4'b0) |=>
      ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

   // R9: interrupt requires a pending flag
   assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != 4'b0));
endmodule

bind sdm_channel sdm_channel_chk u_chk (
   .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .master_en(master_en),
   .flag_clr(flag_clr), .flags(flags), .result(result), .irq(irq)
);

// File: tb/sim_sdm_channel.sv
module sim_sdm_channel;
   localparam int CLK_PERIOD = 10;
   localparam int OSR_D = 32;

   logic               clk = 0;
   logic               rst_n = 0;
   logic               mod_clk = 0, mod_dat = 0;
   logic               chan_en = 0, master_en = 0;
   logic signed [15:0] cmp_hi = 16'sd300, cmp_lo = -16'sd300;
   logic [15:0]        fail_tmo = 16'd100;
   logic [3:0]         irq_en = 4'b0;
   logic               master_irq_en = 0;
   logic [3:0]         flag_clr = 4'b0;
   logic signed [15:0] result;
   logic [3:0]         flags;
   logic               irq;

   int n_chk = 0, n_bad = 0;
   int held;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdm_channel #(.DATA_OSR(OSR_D), .CMP_OSR(8), .OUT_SHIFT(0)) u0 (
      .clk(clk), .rst_n(rst_n), .mod_clk(mod_clk), .mod_dat(mod_dat),
      .chan_en(chan_en), .master_en(master_en), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
      .fail_tmo(fail_tmo), .irq_en(irq_en), .master_irq_en(master_irq_en),
      .flag_clr(flag_clr), .result(result), .flags(flags), .irq(irq)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_bits(input logic [3:0] pat, input int n);
      for (int i = 0; i < n; i++) begin
         mod_dat = pat[i % 4];
         repeat (4) @(negedge clk);
         mod_clk = 1;
         repeat (4) @(negedge clk);
         mod_clk = 0;
      end
   endtask

   task automatic clear_flags(input logic [3:0] m);
      flag_clr = m;
      @(negedge clk);
      flag_clr = 4'b0;
   endtask

   // settle, clear, one decimation window, then check
   task automatic pat_test(input string tag, input logic [3:0] pat,
                           input int hi, input int lo, input int exp_res,
                           input int exp_hi, input int exp_lo);
      cmp_hi = 16'(hi);
      cmp_lo = 16'(lo);
      run_bits(pat, 5 * OSR_D);
      clear_flags(4'hF);
      run_bits(pat, OSR_D);
      chk({tag, " R3/R4 result"}, int'(result), exp_res);
      chk({tag, " R6 ready"}, int'(flags[0]), 1);
      chk({tag, " R5 upper"}, int'(flags[1]), exp_hi);
      chk({tag, " R5 lower"}, int'(flags[2]), exp_lo);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset result", int'(result), 0);
      chk("R1 reset flags", int'(flags), 0);
      chk("R9 reset irq", int'(irq), 0);
      rst_n = 1;
      @(negedge clk);

      // R1: channel enabled but master off: nothing moves
      chan_en = 1;
      run_bits(4'b1111, 40);
      chk("R1 idle flags", int'(flags), 0);
      chk("R1 idle result", int'(result), 0);

      // R2: in-phase start
      master_en = 1;
      run_bits(4'b1111, OSR_D - 1);
      chk("R2 no ready before edge", int'(flags[0]), 0);
      run_bits(4'b1111, 1);
      chk("R2 ready on edge", int'(flags[0]), 1);

      // R3/R4/R5: steady patterns (means 1, -1, 0, 1/2, -1/2)
      pat_test("all-ones",  4'b1111, 300, -300, 32767, 1, 0);
      pat_test("all-zeros", 4'b0000, 300, -300, -32768, 0, 1);
      pat_test("alternate", 4'b0101, 300, -300, 0, 0, 0);
      pat_test("3of4",      4'b0111, 300, -300, 16384, 0, 0);
      pat_test("1of4",      4'b0001, 300, -300, -16384, 0, 0);
      // R5 limits are strict
      pat_test("hi-equal",  4'b0111, 256, -300, 16384, 0, 0);
      pat_test("hi-below",  4'b0111, 255, -300, 16384, 1, 0);
      pat_test("lo-equal",  4'b0001, 300, -256, -16384, 0, 0);
      pat_test("lo-above",  4'b0001, 300, -255, -16384, 0, 1);
      // flags now: ready and lower set

      // R9: interrupt gating
      irq_en = 4'b0001;
      master_irq_en = 0;
      @(negedge clk);
      chk("R9 master off", int'(irq), 0);
      master_irq_en = 1;
      @(negedge clk);
      chk("R9 master on", int'(irq), 1);
      irq_en = 4'b1000;
      @(negedge clk);
      chk("R9 unmasked none", int'(irq), 0);
      irq_en = 4'b0100;
      @(negedge clk);
      chk("R9 lower enabled", int'(irq), 1);

      // R8: clearing one bit leaves the others
      clear_flags(4'b0001);
      chk("R8 cleared ready", int'(flags), 4'b0100);
      clear_flags(4'b0100);
      chk("R8 cleared lower", int'(flags), 0);
      chk("R9 irq drops", int'(irq), 0);

      // R7: stall with timeout 100
      fail_tmo = 16'd100;
      repeat (90) @(negedge clk);
      chk("R7 before timeout", int'(flags[3]), 0);
      repeat (30) @(negedge clk);
      chk("R7 after timeout", int'(flags[3]), 1);
      clear_flags(4'b1000);
      chk("R8 set wins over clear", int'(flags[3]), 1);

      // R7: timeout below floor acts as 64
      fail_tmo = 16'd5;
      run_bits(4'b0101, 4);
      clear_flags(4'hF);
      repeat (50) @(negedge clk);
      chk("R7 floor not yet", int'(flags[3]), 0);
      repeat (30) @(negedge clk);
      chk("R7 floor reached", int'(flags[3]), 1);

      // R1/R7: master off, no stall flag and result held
      master_en = 0;
      @(negedge clk);
      clear_flags(4'hF);
      held = int'(result);
      repeat (200) @(negedge clk);
      chk("R7 no stall when off", int'(flags[3]), 0);
      run_bits(4'b1111, 2 * OSR_D);
      chk("R1 result held", int'(result), held);
      chk("R1 no flags when off", int'(flags), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule